// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory port. A base address is captured on a rising clock edge when the qualify input is high and at least one of two address strobes is active. The two strobes are a processor-side strobe and a controller-side strobe, and both take the address from one shared input bus. After the capture, the two low address bits step through the burst, but only on cycles where the advance input is high. On any other cycle the address stays where it is, which gives a wait state.

A static order input picks between two orderings. In wrapping linear order the low two bits count up by one. In interleaved order the low two bits are the loaded low bits XORed with a beat count. The upper address bits never change within a burst. A last-beat flag marks the fourth beat. An advance on the last beat wraps back to the first beat without a new load.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `word_addr` is all zeros and `last_beat` is 0.
- R2: When `qualify` is 1 and `strobe_p` or `strobe_c` is 1 at a rising edge, `word_addr` equals the sampled `addr_in` from the next cycle on, and `last_beat` is 0.
- R3: When `qualify` is 0, both strobes are ignored. The address holds or advances exactly as if no strobe were present.
- R4: When both strobes are active in the same qualified cycle, one load from `addr_in` takes place, with `strobe_p` given priority. A load always wins over a simultaneous `advance`.
- R5: With `order_sel` = 0 (linear), each advance adds 1 modulo 4 to the two low bits. For example, a load of low bits 2 gives 2, 3, 0, 1.
- R6: With `order_sel` = 1 (interleaved), the low bits equal the loaded low bits XOR the beat count 0, 1, 2, 3. For example, low bits 1 give 1, 0, 3, 2, and low bits 3 give 3, 2, 1, 0.
- R7: With no qualified strobe and `advance` = 0, `word_addr` and `last_beat` keep their values.
- R8: Bits above bit 1 of `word_addr` change only on a load.
- R9: `last_beat` is 1 exactly on the fourth beat of a burst, that is, when the beat count is 3.
- R10: An advance on the last beat returns to the loaded address (beat count 0) without a load, and `last_beat` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| qualify | input | 1 | Enables address capture by either strobe |
| strobe_p | input | 1 | Processor-side address strobe (priority) |
| strobe_c | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step to the next burst beat |
| addr_in | input | ADDR_W | Address to capture |
| word_addr | output | ADDR_W | Current word address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The bench targets these corner cases:

- **Every starting low value in both orderings.** An interleaved burst that was built as an increment would give 1, 2, 3, 0 instead of 1, 0, 3, 2.
- **Wait states in the middle of a burst.** A counter that ran freely would skip addresses.
- **Wrap past the last beat, and a carry into the upper bits.** If the linear increment carried out of bit 1, the upper address would change at the 3-to-0 step.
- **Unqualified strobes, a load together with an advance, and both strobes at once.** A design that ignored `qualify` would reload the address. A design that let the advance win would start the new burst at its second beat.

// File: rtl/burst_pkg.sv
// Package: shared types and constants for the burst address sequencer.
package burst_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_load_ctl.sv
// burst_load_ctl: decides whether this edge captures a new base address.
// Assumes both strobes share one address bus; the processor strobe is
// examined first, so exactly one capture results when both are active.
module burst_load_ctl (
    input  logic qualify,
    input  logic strobe_p,
    input  logic strobe_c,
    output logic load
);
    // Priority decode of the two strobes, gated by qualify.
    always_comb begin
        load = 1'b0;
        if (qualify && strobe_p) begin
            load = 1'b1;
        end else if (qualify && strobe_c) begin
            load = 1'b1;
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// burst_beat_ctr: beat counter for one burst. It clears on a load and
// steps on advance, wrapping modulo the burst length.
// Assumes the load input already carries the strobe priority.
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

    // Beat register: reset, restart on a load, step on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= '0;
        end else if (advance) begin
            beat <= beat + BEAT_W'(1);
        end
    end

    // Last-beat decode.
    always_comb last = (beat == BEAT_LAST);
endmodule

// File: rtl/burst_addr_map.sv
// burst_addr_map: combines the stored base low bits with the beat count
// for the selected order. It is combinational only.
// Linear order adds modulo 2^BEAT_W. Interleaved order XORs bit by bit.
module burst_addr_map
    import burst_pkg::*;
(
    input  order_e            order,
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] addr_lo
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear variant: wrapping add, with no carry out of the field.
    always_comb lin_lo = base_lo + beat;

    // Interleaved variant: one XOR per address bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = base_lo[i] ^ beat[i];
    end

    // Order select.
    always_comb addr_lo = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
// burst_addr_gen: top level of the burst word address sequencer.
// It holds the captured base address and leaves the beat counting and the
// order mapping to its submodules.
// Assumes order_sel changes only together with a load, or between bursts.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_sel,
    input  logic              qualify,
    input  logic              strobe_p,
    input  logic              strobe_c,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic              last_beat
);
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] addr_lo;
    logic [ADDR_W-1:0] base_q;
    order_e            order;

    // Cast the plain order pin to the typed enum.
    always_comb order = order_e'(order_sel);

    burst_load_ctl u_load (
        .qualify  (qualify),
        .strobe_p (strobe_p),
        .strobe_c (strobe_c),
        .load     (load)
    );

    burst_beat_ctr u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .beat    (beat),
        .last    (last_beat)
    );

    // Base address register: captured on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
        end
    end

    burst_addr_map u_map (
        .order   (order),
        .base_lo (base_q[BEAT_W-1:0]),
        .beat    (beat),
        .addr_lo (addr_lo)
    );

    // Output address: fixed upper bits, mapped low bits.
    always_comb word_addr = {base_q[ADDR_W-1:BEAT_W], addr_lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
// burst_addr_gen_chk: checker for burst_addr_gen, attached with bind.
// It watches the ports only.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              order_sel,
    input logic              qualify,
    input logic              strobe_p,
    input logic              strobe_c,
    input logic              advance,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] word_addr,
    input logic              last_beat
);
    logic ld;
    always_comb ld = qualify && (strobe_p || strobe_c);

    // R2 and R4: a qualified strobe captures addr_in and restarts the burst.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (word_addr == $past(addr_in)) && !last_beat);

    // R7: no load and no advance means the outputs hold.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !advance) |=> ($stable(word_addr) || order_sel != $past(order_sel)) && $stable(last_beat));

    // R8: the upper bits change only on a load.
    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(word_addr[ADDR_W-1:2]));

    // R10: an advance on the last beat clears the flag.
    assert_wrap_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && advance && last_beat) |=> !last_beat);

    // R5: in linear order an advance adds one to the low bits.
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && advance && !order_sel) |=>
            (order_sel != $past(order_sel)) || (word_addr[1:0] == $past(word_addr[1:0]) + 2'd1));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_sel (order_sel),
    .qualify   (qualify),
    .strobe_p  (strobe_p),
    .strobe_c  (strobe_c),
    .advance   (advance),
    .addr_in   (addr_in),
    .word_addr (word_addr),
    .last_beat (last_beat)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          order_sel = 1'b0;
    logic          qualify = 1'b0;
    logic          strobe_p = 1'b0;
    logic          strobe_c = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;
    logic          last_beat;

    int total = 0;
    int bad = 0;

    // Scoreboard queues, filled by the driver and drained by the monitor.
    logic [AW-1:0] q_addr[$];
    logic          q_last[$];
    string         q_tag[$];

    // Independent reference model state.
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .qualify(qualify),
        .strobe_p(strobe_p), .strobe_c(strobe_c), .advance(advance),
        .addr_in(addr_in), .word_addr(word_addr), .last_beat(last_beat)
    );

    // Drives one cycle on the falling edge and pushes the expected result.
    task automatic step(input logic sp, input logic sc, input logic q,
                        input logic adv, input logic [AW-1:0] a, input string tag);
        logic [1:0] lo;
        @(negedge clk);
        strobe_p = sp; strobe_c = sc; qualify = q; advance = adv; addr_in = a;
        if (q && (sp || sc)) begin
            m_base = a;
            m_beat = 2'd0;
        end else if (adv) begin
            m_beat = m_beat + 2'd1;
        end
        lo = order_sel ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        q_addr.push_back({m_base[AW-1:2], lo});
        q_last.push_back(m_beat == 2'd3);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares one result shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q_addr.size() > 0) begin
            logic [AW-1:0] ea;
            logic          el;
            string         t;
            ea = q_addr.pop_front();
            el = q_last.pop_front();
            t  = q_tag.pop_front();
            total++;
            if (word_addr !== ea || last_beat !== el) begin
                bad++;
                $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                         t, word_addr, last_beat, ea, el);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        total++;
        if (word_addr !== '0 || last_beat !== 1'b0) begin
            bad++;
            $display("FAIL R1: addr=%h last=%b expected addr=0 last=0", word_addr, last_beat);
        end
        rst_n = 1'b1;

        // R2 and R5: linear burst from low bits 2, with a wait state (R7) mid-burst.
        order_sel = 1'b0;
        step(1, 0, 1, 0, 20'hABCD2, "R2 load");
        step(0, 0, 0, 1, '0, "R5 lin beat1");
        step(0, 0, 0, 0, '0, "R7 hold");
        step(0, 0, 0, 1, '0, "R5 R8 lin wrap no carry");
        step(0, 0, 0, 1, '0, "R9 last beat");
        step(0, 0, 0, 0, '0, "R7 hold last");
        step(0, 0, 0, 1, '0, "R10 wrap to first");
        step(0, 0, 0, 1, '0, "R10 second pass");

        // R6: interleaved order for every start value, loaded by the controller strobe.
        order_sel = 1'b1;
        for (int s = 0; s < 4; s++) begin
            step(0, 1, 1, 0, 20'h12340 | 20'(s), "R6 R2 ctrl load");
            for (int k = 0; k < 4; k++) step(0, 0, 0, 1, '0, "R6 R9 R10 interleave");
        end

        // R3: unqualified strobes are ignored while holding and while advancing.
        step(1, 1, 0, 0, 20'hFFFFF, "R3 ignored hold");
        step(1, 0, 0, 1, 20'h00003, "R3 ignored advance");
        step(0, 1, 0, 1, 20'h00003, "R3 ignored advance");

        // R4: both strobes together give a single load; a load beats an advance.
        step(1, 1, 1, 1, 20'h55551, "R4 both strobes with advance");
        step(0, 0, 0, 1, '0, "R4 R6 next beat");
        step(0, 1, 1, 1, 20'h0AAA3, "R4 ctrl load over advance");

        // R5: linear order from every start value.
        order_sel = 1'b0;
        for (int s = 0; s < 4; s++) begin
            step(1, 0, 1, 0, 20'hFFFFC | 20'(s), "R5 R8 lin load");
            for (int k = 0; k < 5; k++) step(0, 0, 0, 1, '0, "R5 R8 R9 R10 linear");
        end

        // Reset in the middle of a burst (R1).
        step(0, 0, 0, 0, '0, "R7 hold");
        @(negedge clk);
        rst_n = 1'b0;
        m_base = '0; m_beat = 2'd0;
        @(negedge clk);
        total++;
        if (word_addr !== '0 || last_beat !== 1'b0) begin
            bad++;
            $display("FAIL R1: addr=%h last=%b expected addr=0 last=0", word_addr, last_beat);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, '0, "R1 R7 idle after reset");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule